// File: doc/BRIEF.md
# Receive Buffer Resource Ring Manager

This block keeps track of the buffer that incoming packets are written into. A table of buffer records sits in memory as a ring between a start offset and an end offset. Each record has four 16-bit words: buffer address low, buffer address high, word count low, word count high. On request, the block reads the record at its read pointer through a simple word-wide memory port. It loads the address and count into its current-buffer registers, then moves the pointer on by one record, wrapping at the end offset. If the pointer lands on the software-owned write pointer, it raises a one-cycle exhaustion event.

Packet accounting uses the same registers. For each packet, the receive path presents the byte count. The block adds four bytes for the frame check sequence and rounds the result up to the data-path granularity. It then either consumes that space or refuses the packet because the buffer is too small. When a packet is the last one that fits, the block fetches the next record by itself. If the ring has no free record left, it stalls reception instead. While stalled, packets are dropped until a fetch completes.

All memory addresses are the 16-bit upper-address input joined with a 16-bit ring offset. In wide (32-bit) data mode each record word sits in a 4-byte slot, and only the low half of the slot is used. A record is then 16 bytes rather than 8.

Top module: `rx_resource_ring`

## Requirements
- R1: After reset, busy, stalled, mem_req, pkt_done and both event outputs are 0, rd_ptr, buf_addr and words_left are 0, and the internal threshold is 0x02F8.
- R2: A fetch reads four words at addresses {ring_upper, rd_ptr + k*step} for k = 0..3, where step is 2 bytes in narrow mode and 4 bytes in wide mode. It then sets buf_addr = {word1, word0} and words_left = {word3, word2}. While mem_req is high and not acknowledged, mem_addr holds steady.
- R3: A completed fetch advances rd_ptr by 8 bytes in narrow mode or 16 bytes in wide mode. A result equal to ring_end is replaced by ring_start. rd_ptr changes only on fetch completion or on a rp_we load.
- R4: evt_exhaust pulses for one cycle, in the cycle in which the advanced rd_ptr first shows, exactly when that pointer equals ring_wr.
- R5: A fetch_req that arrives while a fetch is running or already queued is held as one queued fetch. A burst of requests during one fetch yields exactly one extra fetch.
- R6: An accepted packet has a padded length P, which is (pkt_bytes + 4) rounded up to a multiple of 2 in narrow mode or 4 in wide mode. Accepting it sets pkt_stored, adds P to buf_addr and subtracts P/2 from words_left, all visible the cycle after pkt_valid. pkt_valid is only presented while busy is low.
- R7: If P exceeds 2*words_left, the packet is refused. evt_overflow and pkt_last are set, pkt_stored stays 0, and buf_addr and words_left stay unchanged.
- R8: An accepted packet is marked pkt_last when the new words_left is below the threshold (reset value 0x02F8, loaded by thr_we).
- R9: When a packet is marked last and rd_ptr differs from ring_wr, the next record is fetched without a request. When they are equal, stalled is set instead.
- R10: While stalled, each packet gives pkt_done with pkt_stored and pkt_last at 0, and buf_addr and words_left do not change. The next completed fetch clears stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 selects 32-bit data slots |
| ring_upper | input | 16 | Upper half of every memory address |
| ring_start | input | 16 | Ring start offset |
| ring_end | input | 16 | Ring end offset (one past last record) |
| ring_wr | input | 16 | Software write pointer |
| rp_we | input | 1 | Load rd_ptr |
| rp_wdata | input | 16 | Value for rd_ptr load |
| thr_we | input | 1 | Load end-of-buffer threshold |
| thr_wdata | input | 16 | Threshold value in words |
| fetch_req | input | 1 | Request a record fetch |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 32 | Byte address of requested word |
| mem_ack | input | 1 | Read data valid for mem_req |
| mem_rdata | input | 16 | Read data |
| pkt_valid | input | 1 | Packet length presented |
| pkt_bytes | input | 16 | Packet byte count without FCS |
| pkt_done | output | 1 | Packet result valid |
| pkt_stored | output | 1 | Packet accepted into buffer |
| pkt_last | output | 1 | Packet marked last in buffer |
| evt_exhaust | output | 1 | Ring exhausted pulse |
| evt_overflow | output | 1 | Buffer area exceeded pulse |
| stalled | output | 1 | Reception stalled |
| busy | output | 1 | Fetch running or queued |
| rd_ptr | output | 16 | Ring read pointer |
| buf_addr | output | 32 | Current buffer byte address |
| words_left | output | 32 | Remaining 16-bit words in buffer |

## Verification
Several rules are checked by assertions on every cycle. The memory address holds while a read waits, and the read pointer stays still except on fetch completion or load. Exhaustion only fires with the pointer on the write pointer, a refused packet is always marked last, stalling only starts on a last packet, and a stalled packet leaves the buffer state alone. The bench scenarios show the rest. These are the padding arithmetic in both data modes at the fit/no-fit and threshold boundaries, the wrap of the pointer, and the single queued fetch. They also cover the automatic fetch after a last packet and the full stall and release sequence.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

  localparam int unsigned REC_WORDS = 4;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_RUN  = 1'b1
  } fetch_state_e;

  // Round a stored length up to the slot granularity of the data path.
  function automatic logic [31:0] pad_bytes(input logic [31:0] rx, input logic wide);
    logic [31:0] m;
    m = wide ? 32'd3 : 32'd1;
    return ((rx - 32'd1) | m) + 32'd1;
  endfunction

endpackage

// File: rtl/rrm_fetch.sv
module rrm_fetch import rrm_pkg::*; #(
  parameter int unsigned OFS_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic                 wide,
  input  logic [OFS_W-1:0]     upper,
  input  logic [OFS_W-1:0]     base,
  output logic                 mem_req,
  output logic [2*OFS_W-1:0]   mem_addr,
  input  logic                 mem_ack,
  input  logic [OFS_W-1:0]     mem_rdata,
  output logic                 busy,
  output logic                 done,
  output logic [2*OFS_W-1:0]   rec_addr,
  output logic [2*OFS_W-1:0]   rec_cnt
);
  localparam int unsigned IDX_W = $clog2(REC_WORDS);

  fetch_state_e     state;
  logic [IDX_W-1:0] idx;
  logic [OFS_W-1:0] ofs;
  logic [OFS_W-1:0] up_q;
  logic             wide_q;
  logic [OFS_W-1:0] wd [REC_WORDS];
  logic [OFS_W-1:0] step;

  assign step     = wide_q ? OFS_W'(4) : OFS_W'(2);
  assign mem_addr = {up_q, ofs};
  assign busy     = (state == FS_RUN) | done;
  assign rec_addr = {wd[1], wd[0]};
  assign rec_cnt  = {wd[3], wd[2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= FS_IDLE;
      mem_req <= 1'b0;
      done    <= 1'b0;
      idx     <= '0;
      ofs     <= '0;
      up_q    <= '0;
      wide_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        FS_IDLE: if (go) begin
          state   <= FS_RUN;
          mem_req <= 1'b1;
          idx     <= '0;
          ofs     <= base;
          up_q    <= upper;
          wide_q  <= wide;
        end
        FS_RUN: if (mem_ack) begin
          if (idx == IDX_W'(REC_WORDS - 1)) begin
            state   <= FS_IDLE;
            mem_req <= 1'b0;
            done    <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            ofs <= ofs + step;
          end
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  // One capture register per record word.
  for (genvar g = 0; g < REC_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (state == FS_RUN && mem_ack && idx == IDX_W'(g))
        wd[g] <= mem_rdata;
    end
  end

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: rtl/rrm_ptr.sv
module rrm_ptr #(
  parameter int unsigned OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             wide,
  input  logic [OFS_W-1:0] start,
  input  logic [OFS_W-1:0] stop,
  input  logic [OFS_W-1:0] wr,
  input  logic             ld,
  input  logic [OFS_W-1:0] ld_val,
  output logic [OFS_W-1:0] rp,
  output logic             exhaust
);
  logic [OFS_W-1:0] nxt;
  logic [OFS_W-1:0] wrapped;

  assign nxt     = rp + (wide ? OFS_W'(16) : OFS_W'(8));
  assign wrapped = (nxt == stop) ? start : nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rp      <= '0;
      exhaust <= 1'b0;
    end else begin
      exhaust <= 1'b0;
      if (adv) begin
        rp      <= wrapped;
        exhaust <= (wrapped == wr);
      end else if (ld) begin
        rp <= ld_val;
      end
    end
  end

  // R3
  ptr_still_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !ld) |=> $stable(rp));

  // R4
  exhaust_meet_chk: assert property (@(posedge clk) disable iff (rst)
    exhaust |-> (rp == $past(wr)));

endmodule

// File: rtl/rrm_pkt.sv
module rrm_pkt import rrm_pkg::*; #(
  parameter int unsigned OFS_W = 16,
  parameter int unsigned LEN_W = 16
) (
  input  logic               wide,
  input  logic [LEN_W-1:0]   nbytes,
  input  logic [2*OFS_W-1:0] cur_addr,
  input  logic [2*OFS_W-1:0] cur_words,
  input  logic [OFS_W-1:0]   thr,
  output logic               fits,
  output logic [2*OFS_W-1:0] new_addr,
  output logic [2*OFS_W-1:0] new_words,
  output logic               near_end
);
  localparam int unsigned CW = 2 * OFS_W;
  localparam int unsigned FCS_BYTES = 4;

  logic [CW-1:0] rx;
  logic [CW-1:0] padded;

  assign rx        = {{(CW-LEN_W){1'b0}}, nbytes} + CW'(FCS_BYTES);
  assign padded    = CW'(pad_bytes(32'(rx), wide));
  assign fits      = {1'b0, padded} <= {cur_words, 1'b0};
  assign new_addr  = cur_addr + padded;
  assign new_words = cur_words - (padded >> 1);
  assign near_end  = new_words < {{OFS_W{1'b0}}, thr};

endmodule

// File: rtl/rx_resource_ring.sv
module rx_resource_ring #(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned LEN_W     = 16,
  parameter logic [15:0] THR_RESET = 16'h02F8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wide,
  input  logic [OFS_W-1:0]     ring_upper,
  input  logic [OFS_W-1:0]     ring_start,
  input  logic [OFS_W-1:0]     ring_end,
  input  logic [OFS_W-1:0]     ring_wr,
  input  logic                 rp_we,
  input  logic [OFS_W-1:0]     rp_wdata,
  input  logic                 thr_we,
  input  logic [OFS_W-1:0]     thr_wdata,
  input  logic                 fetch_req,
  output logic                 mem_req,
  output logic [2*OFS_W-1:0]   mem_addr,
  input  logic                 mem_ack,
  input  logic [OFS_W-1:0]     mem_rdata,
  input  logic                 pkt_valid,
  input  logic [LEN_W-1:0]     pkt_bytes,
  output logic                 pkt_done,
  output logic                 pkt_stored,
  output logic                 pkt_last,
  output logic                 evt_exhaust,
  output logic                 evt_overflow,
  output logic                 stalled,
  output logic                 busy,
  output logic [OFS_W-1:0]     rd_ptr,
  output logic [2*OFS_W-1:0]   buf_addr,
  output logic [2*OFS_W-1:0]   words_left
);
  localparam int unsigned CW = 2 * OFS_W;

  logic          f_busy, f_done, go, pending;
  logic [CW-1:0] rec_addr, rec_cnt;
  logic [OFS_W-1:0] thr;
  logic          fits, near_end, mark_last;
  logic [CW-1:0] new_addr, new_words;

  assign go        = !f_busy && (fetch_req || pending);
  assign busy      = f_busy | pending;
  assign mark_last = fits ? near_end : 1'b1;

  rrm_fetch #(.OFS_W(OFS_W)) u_fetch (
    .clk(clk), .rst(rst), .go(go), .wide(cfg_wide), .upper(ring_upper),
    .base(rd_ptr), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .busy(f_busy), .done(f_done),
    .rec_addr(rec_addr), .rec_cnt(rec_cnt)
  );

  rrm_ptr #(.OFS_W(OFS_W)) u_ptr (
    .clk(clk), .rst(rst), .adv(f_done), .wide(cfg_wide), .start(ring_start),
    .stop(ring_end), .wr(ring_wr), .ld(rp_we), .ld_val(rp_wdata),
    .rp(rd_ptr), .exhaust(evt_exhaust)
  );

  rrm_pkt #(.OFS_W(OFS_W), .LEN_W(LEN_W)) u_pkt (
    .wide(cfg_wide), .nbytes(pkt_bytes), .cur_addr(buf_addr),
    .cur_words(words_left), .thr(thr), .fits(fits), .new_addr(new_addr),
    .new_words(new_words), .near_end(near_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pending      <= 1'b0;
      stalled      <= 1'b0;
      thr          <= OFS_W'(THR_RESET);
      buf_addr     <= '0;
      words_left   <= '0;
      pkt_done     <= 1'b0;
      pkt_stored   <= 1'b0;
      pkt_last     <= 1'b0;
      evt_overflow <= 1'b0;
    end else begin
      pkt_done     <= 1'b0;
      pkt_stored   <= 1'b0;
      pkt_last     <= 1'b0;
      evt_overflow <= 1'b0;
      if (thr_we) thr <= thr_wdata;
      if (go) pending <= 1'b0;
      if (fetch_req && !go) pending <= 1'b1;
      if (f_done) begin
        buf_addr   <= rec_addr;
        words_left <= rec_cnt;
        stalled    <= 1'b0;
      end
      if (pkt_valid) begin
        pkt_done <= 1'b1;
        if (!stalled) begin
          if (fits) begin
            buf_addr   <= new_addr;
            words_left <= new_words;
            pkt_stored <= 1'b1;
          end else begin
            evt_overflow <= 1'b1;
          end
          pkt_last <= mark_last;
          if (mark_last) begin
            if (rd_ptr == ring_wr) stalled <= 1'b1;
            else                   pending <= 1'b1;
          end
        end
      end
    end
  end

  // R6
  pkt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> !busy);

  // R7
  refuse_last_chk: assert property (@(posedge clk) disable iff (rst)
    evt_overflow |-> (pkt_last && !pkt_stored));

  // R9
  stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stalled) |-> (pkt_done && pkt_last));

  // R10
  stall_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (stalled && pkt_valid) |=> ($stable(buf_addr) && $stable(words_left) && !pkt_stored));

endmodule

// File: tb/rx_resource_ring_test.sv
`timescale 1ns/1ps
module rx_resource_ring_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wide = 1'b0;
  logic [15:0] ring_upper = 16'h0012;
  logic [15:0] ring_start = 16'h0000;
  logic [15:0] ring_end   = 16'h0100;
  logic [15:0] ring_wr    = 16'h01F0;
  logic        rp_we = 1'b0;
  logic [15:0] rp_wdata = '0;
  logic        thr_we = 1'b0;
  logic [15:0] thr_wdata = '0;
  logic        fetch_req = 1'b0;
  logic        mem_req, mem_ack;
  logic [31:0] mem_addr;
  logic [15:0] mem_rdata;
  logic        pkt_valid = 1'b0;
  logic [15:0] pkt_bytes = '0;
  logic        pkt_done, pkt_stored, pkt_last, evt_exhaust, evt_overflow, stalled, busy;
  logic [15:0] rd_ptr;
  logic [31:0] buf_addr, words_left;

  int tests = 0;
  int fails = 0;
  int upper_bad = 0;
  logic [15:0] mem [0:511];

  always #2.5 clk = ~clk;

  rx_resource_ring uut (
    .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .ring_upper(ring_upper),
    .ring_start(ring_start), .ring_end(ring_end), .ring_wr(ring_wr),
    .rp_we(rp_we), .rp_wdata(rp_wdata), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .fetch_req(fetch_req), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .pkt_valid(pkt_valid),
    .pkt_bytes(pkt_bytes), .pkt_done(pkt_done), .pkt_stored(pkt_stored),
    .pkt_last(pkt_last), .evt_exhaust(evt_exhaust), .evt_overflow(evt_overflow),
    .stalled(stalled), .busy(busy), .rd_ptr(rd_ptr), .buf_addr(buf_addr),
    .words_left(words_left)
  );

  // Zero-wait memory model
  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[9:1]];

  always @(negedge clk) if (mem_req && mem_addr[31:16] != ring_upper) upper_bad++;

  typedef struct packed {
    logic        wide;
    logic [31:0] w_in;
    logic [15:0] nbytes;
    logic        exp_stored;
    logic [31:0] exp_words;
    logic [15:0] exp_delta;
    logic        exp_last;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    {1'b0, 32'h1000, 16'd60, 1'b1, 32'h0FE0, 16'd64, 1'b0},
    {1'b0, 32'h1000, 16'd61, 1'b1, 32'h0FDF, 16'd66, 1'b0},
    {1'b1, 32'h1000, 16'd61, 1'b1, 32'h0FDE, 16'd68, 1'b0},
    {1'b1, 32'h1000, 16'd62, 1'b1, 32'h0FDE, 16'd68, 1'b0},
    {1'b0, 32'h0300, 16'd20, 1'b1, 32'h02F4, 16'd24, 1'b1},
    {1'b0, 32'h0300, 16'd12, 1'b1, 32'h02F8, 16'd16, 1'b0},
    {1'b0, 32'h0010, 16'd28, 1'b1, 32'h0000, 16'd32, 1'b1},
    {1'b0, 32'h0010, 16'd29, 1'b0, 32'h0010, 16'd0,  1'b1},
    {1'b1, 32'h0010, 16'd27, 1'b1, 32'h0000, 16'd32, 1'b1},
    {1'b1, 32'h0010, 16'd29, 1'b0, 32'h0010, 16'd0,  1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
  endtask

  task automatic put_rec(input logic wide, input logic [15:0] ofs,
                         input logic [31:0] a, input logic [31:0] c);
    logic [15:0] w [4];
    logic [15:0] step;
    w[0] = a[15:0]; w[1] = a[31:16]; w[2] = c[15:0]; w[3] = c[31:16];
    step = wide ? 16'd4 : 16'd2;
    for (int k = 0; k < 4; k++) begin
      mem[(ofs + 16'(k) * step) >> 1] = w[k];
      if (wide) mem[(ofs + 16'(k) * step + 16'd2) >> 1] = 16'hDEAD;
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic load_rp(input logic [15:0] v);
    @(negedge clk); rp_we = 1'b1; rp_wdata = v;
    @(negedge clk); rp_we = 1'b0;
  endtask

  task automatic do_fetch();
    @(negedge clk); fetch_req = 1'b1;
    @(negedge clk); fetch_req = 1'b0;
    wait_idle();
  endtask

  task automatic send_pkt(input logic [15:0] n);
    @(negedge clk); pkt_valid = 1'b1; pkt_bytes = n;
    @(negedge clk); pkt_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] a0;
    clear_mem();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 stalled", stalled, 0);
    check("R1 rd_ptr", rd_ptr, 0);
    check("R1 buf_addr", buf_addr, 0);
    check("R1 words_left", words_left, 0);
    check("R1 outputs", {mem_req, pkt_done, evt_exhaust, evt_overflow}, 0);

    // Table walk: R2 R3 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      cfg_wide = VECS[v].wide;
      clear_mem();
      put_rec(VECS[v].wide, 16'h0040, 32'h00AB1000, VECS[v].w_in);
      load_rp(16'h0040);
      do_fetch();
      check("R2 buf_addr", buf_addr, 32'h00AB1000);
      check("R2 words_left", words_left, VECS[v].w_in);
      check("R3 advance", rd_ptr, VECS[v].wide ? 32'h50 : 32'h48);
      send_pkt(VECS[v].nbytes);
      check("R6 stored", pkt_stored, VECS[v].exp_stored);
      check("R6 words_left", words_left, VECS[v].exp_words);
      check("R6 buf_addr", buf_addr, 32'h00AB1000 + VECS[v].exp_delta);
      check("R7 overflow", evt_overflow, !VECS[v].exp_stored);
      check("R8 last", pkt_last, VECS[v].exp_last);
      wait_idle();
    end

    // R3 wrap, narrow
    cfg_wide = 1'b0; clear_mem();
    ring_start = 16'h0020; ring_end = 16'h0060; ring_wr = 16'h01F0;
    put_rec(1'b0, 16'h0058, 32'h00001234, 32'h100);
    load_rp(16'h0058); do_fetch();
    check("R3 wrap narrow", rd_ptr, 16'h0020);
    check("R4 no exhaust", evt_exhaust, 0);

    // R3 wrap wide and R4 exhaustion
    cfg_wide = 1'b1; ring_wr = 16'h0020;
    put_rec(1'b1, 16'h0050, 32'h00005678, 32'h100);
    load_rp(16'h0050); do_fetch();
    check("R3 wrap wide", rd_ptr, 16'h0020);
    check("R4 exhaust", evt_exhaust, 1);
    @(negedge clk);
    check("R4 pulse width", evt_exhaust, 0);

    // R5 queued fetch
    cfg_wide = 1'b0; ring_start = 16'h0000; ring_end = 16'h0100; ring_wr = 16'h01F0;
    load_rp(16'h0040);
    @(negedge clk); fetch_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); fetch_req = 1'b0;
    wait_idle();
    check("R5 one queued fetch", rd_ptr, 16'h0050);

    // R9 automatic fetch after last packet
    clear_mem();
    put_rec(1'b0, 16'h0040, 32'h00AB1000, 32'h0300);
    put_rec(1'b0, 16'h0048, 32'h00AB2000, 32'h0900);
    load_rp(16'h0040); do_fetch();
    send_pkt(16'd20);
    check("R9 last", pkt_last, 1);
    wait_idle();
    check("R9 auto buf_addr", buf_addr, 32'h00AB2000);
    check("R9 auto words", words_left, 32'h0900);
    check("R9 auto rd_ptr", rd_ptr, 16'h0050);
    check("R9 no stall", stalled, 0);

    // R9 stall, R10 drop and release
    clear_mem(); ring_wr = 16'h0048;
    put_rec(1'b0, 16'h0040, 32'h00AB1000, 32'h0300);
    load_rp(16'h0040); do_fetch();
    check("R4 exhaust on fetch", evt_exhaust, 1);
    send_pkt(16'd20);
    check("R9 stalled", stalled, 1);
    check("R9 no fetch", busy, 0);
    a0 = buf_addr;
    send_pkt(16'd60);
    check("R10 done", pkt_done, 1);
    check("R10 not stored", {pkt_stored, pkt_last}, 0);
    check("R10 addr kept", buf_addr, a0);
    check("R10 words kept", words_left, 32'h02F4);
    put_rec(1'b0, 16'h0048, 32'h00AC0000, 32'h0800);
    ring_wr = 16'h01F0;
    do_fetch();
    check("R10 released", stalled, 0);
    send_pkt(16'd60);
    check("R10 accepted again", pkt_stored, 1);
    wait_idle();

    // R8 loaded threshold
    @(negedge clk); thr_we = 1'b1; thr_wdata = 16'h0100;
    @(negedge clk); thr_we = 1'b0;
    clear_mem();
    put_rec(1'b0, 16'h0040, 32'h00AB1000, 32'h0300);
    load_rp(16'h0040); do_fetch();
    send_pkt(16'd20);
    check("R8 loaded threshold", pkt_last, 0);
    check("R8 words", words_left, 32'h02F4);

    check("R2 upper address", upper_bad, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule